// File: doc/BRIEF.md
# Jump Class Branch Resolver

This block resolves the control-flow outcome of one jump-class instruction of a 64-bit register virtual machine. Each cycle a decode stage may present one instruction: its slot index, the 4-bit operation code, the source-select bit, the class bit (full-width or low-half compare), the signed 16-bit offset field, the 32-bit immediate, the call subtype field and the two operand values. The block evaluates the condition, forms the next slot index, and flags calls, returns and undefined encodings. The result is registered, so it appears one clock after the inputs are sampled.

Slot indices count 64-bit instruction slots and wrap modulo 2^PC_W. Every displacement is measured from the slot after the current one. Call execution, a return stack and register writeback belong to the surrounding pipeline. This block only reports a call or a return, and it supplies the target of a program-local call.

Top module: `jump_resolve`

## Requirements
- R1: While reset is asserted, and at the first edge after it, every output is zero, including `nxt_pc_o`.
- R2: Conditions are chosen by `code_i`: 1 equal, 2 unsigned greater, 3 unsigned greater-or-equal, 4 bit test (the AND of the operands is non-zero), 5 not equal, 6 signed greater, 7 signed greater-or-equal, 10 unsigned less, 11 unsigned less-or-equal, 12 signed less, 13 signed less-or-equal. `taken_o` is 1 exactly when the condition holds.
- R3: With `half_i`=1 only bits 31:0 of each operand are compared, and bit 31 is the sign for signed conditions. With `half_i`=0 all 64 bits are compared, and bit 63 is the sign.
- R4: With `use_reg_i`=1 the second operand is `rhs_i`. With `use_reg_i`=0 it is `imm_i` sign-extended to 64 bits.
- R5: When a conditional branch is taken, `nxt_pc_o` = pc + 1 + sign-extended `ofs_i`. When it is not taken, `nxt_pc_o` = pc + 1. Both values wrap modulo 2^PC_W.
- R6: Code 0 with `use_reg_i`=0 is always taken. With `half_i`=0 its displacement is `ofs_i`. With `half_i`=1 its displacement is the signed `imm_i`.
- R7: Code 8 with `half_i`=0 and `use_reg_i`=0 is a call and raises `call_o`. If `sub_i` is 0 or 2, it is a helper call: `helper_o`=1, `taken_o`=0, and `nxt_pc_o` = pc + 1. If `sub_i` is 1, it is a local call: `taken_o`=1 and `nxt_pc_o` = pc + 1 + signed `imm_i`.
- R8: Code 9 with `half_i`=0 and `use_reg_i`=0 raises `exit_o`, with `taken_o`=0 and `nxt_pc_o` = pc + 1.
- R9: The following encodings raise `illegal_o`: codes 14 and 15; code 0 with `use_reg_i`=1; code 8 or 9 with `half_i`=1 or `use_reg_i`=1; code 8 with `sub_i` above 2. In each case `taken_o`, `call_o`, `helper_o` and `exit_o` are 0, and `nxt_pc_o` = pc + 1.
- R10: Outputs follow the inputs sampled at the previous rising edge. When `in_vld_i` was 0 at that edge, `out_vld_o` and all flags are 0 and `nxt_pc_o` is 0. At most one of `call_o`, `exit_o` and `illegal_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld_i | input | 1 | An instruction is presented this cycle |
| pc_i | input | PC_W | Slot index of the instruction |
| code_i | input | 4 | Operation code |
| use_reg_i | input | 1 | 1: register operand, 0: immediate operand |
| half_i | input | 1 | 1: low 32-bit class, 0: 64-bit class |
| sub_i | input | 4 | Call subtype field |
| ofs_i | input | 16 | Signed offset field |
| imm_i | input | 32 | Signed immediate field |
| lhs_i | input | 64 | Destination register value |
| rhs_i | input | 64 | Source register value |
| out_vld_o | output | 1 | Registered result is valid |
| taken_o | output | 1 | Control flow leaves the fall-through path |
| nxt_pc_o | output | PC_W | Next slot index |
| call_o | output | 1 | Call request |
| helper_o | output | 1 | The call is a helper call |
| exit_o | output | 1 | Return request |
| illegal_o | output | 1 | Undefined encoding |

## Verification
The bench builds the block with PC_W=16, so the slot index is narrower than the 32-bit immediate. This makes wrap-around past the top of the index space reachable, both backwards below zero and forwards past the top. It also exposes the truncation of far immediate displacements in jumps and local calls. Operand pairs are often forced to agree in their low half and differ in their high half, so the compare-width choice decides the outcome of equality and signed tests.

// File: rtl/jump_resolve_pkg.sv
package jump_resolve_pkg;

    localparam int OFS_W  = 16;
    localparam int IMM_W  = 32;
    localparam int OPND_W = 64;
    localparam int HALF_W = 32;
    localparam int SUB_W  = 4;

    typedef enum logic [3:0] {
        OP_JA   = 4'h0,
        OP_EQ   = 4'h1,
        OP_UGT  = 4'h2,
        OP_UGE  = 4'h3,
        OP_BIT  = 4'h4,
        OP_NE   = 4'h5,
        OP_SGT  = 4'h6,
        OP_SGE  = 4'h7,
        OP_CALL = 4'h8,
        OP_RET  = 4'h9,
        OP_ULT  = 4'ha,
        OP_ULE  = 4'hb,
        OP_SLT  = 4'hc,
        OP_SLE  = 4'hd,
        OP_RSV0 = 4'he,
        OP_RSV1 = 4'hf
    } br_op_e;

    typedef enum logic [2:0] {
        K_COND,
        K_JUMP,
        K_HELPER,
        K_LOCAL,
        K_RET,
        K_BAD
    } br_kind_e;

    localparam logic [SUB_W-1:0] SUB_HELPER_ADDR = 4'd0;
    localparam logic [SUB_W-1:0] SUB_LOCAL       = 4'd1;
    localparam logic [SUB_W-1:0] SUB_HELPER_ID   = 4'd2;

endpackage

// File: rtl/jump_cmp.sv
module jump_cmp
    import jump_resolve_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  br_op_e       op_i,
    output logic         hit_o
);

    logic same;
    logic u_less;
    logic s_less;

    always_comb begin
        same   = (a_i == b_i);
        u_less = (a_i < b_i);
        s_less = ($signed(a_i) < $signed(b_i));
        case (op_i)
            OP_EQ:   hit_o = same;
            OP_NE:   hit_o = !same;
            OP_UGT:  hit_o = !u_less && !same;
            OP_UGE:  hit_o = !u_less;
            OP_ULT:  hit_o = u_less;
            OP_ULE:  hit_o = u_less || same;
            OP_SGT:  hit_o = !s_less && !same;
            OP_SGE:  hit_o = !s_less;
            OP_SLT:  hit_o = s_less;
            OP_SLE:  hit_o = s_less || same;
            OP_BIT:  hit_o = |(a_i & b_i);
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/jump_target.sv
module jump_target #(
    parameter int PC_W   = 32,
    parameter int DISP_W = 32
) (
    input  logic [PC_W-1:0]          pc_i,
    input  logic signed [DISP_W-1:0] disp_i,
    output logic [PC_W-1:0]          tgt_o
);

    localparam int EXT_W = (PC_W > DISP_W) ? PC_W : DISP_W;

    assign tgt_o = PC_W'(EXT_W'(pc_i) + EXT_W'(disp_i) + EXT_W'(1));

endmodule

// File: rtl/jump_decode.sv
module jump_decode
    import jump_resolve_pkg::*;
(
    input  br_op_e           op_i,
    input  logic             use_reg_i,
    input  logic             half_i,
    input  logic [SUB_W-1:0] sub_i,
    output br_kind_e         kind_o
);

    always_comb begin
        kind_o = K_BAD;
        case (op_i)
            OP_JA: begin
                if (!use_reg_i) kind_o = K_JUMP;
            end
            OP_CALL: begin
                if (!use_reg_i && !half_i) begin
                    if (sub_i == SUB_LOCAL)
                        kind_o = K_LOCAL;
                    else if (sub_i == SUB_HELPER_ADDR || sub_i == SUB_HELPER_ID)
                        kind_o = K_HELPER;
                end
            end
            OP_RET: begin
                if (!use_reg_i && !half_i) kind_o = K_RET;
            end
            OP_RSV0, OP_RSV1: kind_o = K_BAD;
            default: kind_o = K_COND;
        endcase
    end

endmodule

// File: rtl/jump_resolve.sv
module jump_resolve
    import jump_resolve_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [3:0]        code_i,
    input  logic              use_reg_i,
    input  logic              half_i,
    input  logic [3:0]        sub_i,
    input  logic [15:0]       ofs_i,
    input  logic [31:0]       imm_i,
    input  logic [63:0]       lhs_i,
    input  logic [63:0]       rhs_i,
    output logic              out_vld_o,
    output logic              taken_o,
    output logic [PC_W-1:0]   nxt_pc_o,
    output logic              call_o,
    output logic              helper_o,
    output logic              exit_o,
    output logic              illegal_o
);

    localparam int N_LANE = 2;

    typedef struct packed {
        logic            vld;
        logic            taken;
        logic            call;
        logic            helper;
        logic            ret;
        logic            bad;
        logic [PC_W-1:0] npc;
    } res_t;

    br_op_e             op;
    br_kind_e           kind;
    logic [OPND_W-1:0]  opnd_b;
    logic [N_LANE-1:0]  lane_hit;
    logic               cond_hit;
    logic [IMM_W-1:0]   ofs_ext;
    logic [IMM_W-1:0]   disp;
    logic [PC_W-1:0]    tgt;
    logic [PC_W-1:0]    fall;
    res_t               res_d;
    res_t               res_q;

    assign op     = br_op_e'(code_i);
    assign opnd_b = use_reg_i ? rhs_i : {{(OPND_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};

    jump_decode u_dec (
        .op_i      (op),
        .use_reg_i (use_reg_i),
        .half_i    (half_i),
        .sub_i     (sub_i),
        .kind_o    (kind)
    );

    // lane 0 compares the full width, lane 1 only the low half
    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        localparam int LW = (g == 0) ? OPND_W : HALF_W;
        jump_cmp #(.W(LW)) u_cmp (
            .a_i   (lhs_i[LW-1:0]),
            .b_i   (opnd_b[LW-1:0]),
            .op_i  (op),
            .hit_o (lane_hit[g])
        );
    end

    assign cond_hit = half_i ? lane_hit[1] : lane_hit[0];

    // the immediate carries the displacement for long jumps and local calls
    assign ofs_ext = {{(IMM_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
    assign disp    = ((kind == K_JUMP && half_i) || kind == K_LOCAL) ? imm_i : ofs_ext;

    jump_target #(.PC_W(PC_W), .DISP_W(IMM_W)) u_tgt (
        .pc_i   (pc_i),
        .disp_i (disp),
        .tgt_o  (tgt)
    );

    jump_target #(.PC_W(PC_W), .DISP_W(1)) u_fall (
        .pc_i   (pc_i),
        .disp_i (1'b0),
        .tgt_o  (fall)
    );

    always_comb begin
        res_d     = '0;
        res_d.vld = in_vld_i;
        if (in_vld_i) begin
            res_d.npc = fall;
            case (kind)
                K_COND: begin
                    res_d.taken = cond_hit;
                    if (cond_hit) res_d.npc = tgt;
                end
                K_JUMP: begin
                    res_d.taken = 1'b1;
                    res_d.npc   = tgt;
                end
                K_LOCAL: begin
                    res_d.call  = 1'b1;
                    res_d.taken = 1'b1;
                    res_d.npc   = tgt;
                end
                K_HELPER: begin
                    res_d.call   = 1'b1;
                    res_d.helper = 1'b1;
                end
                K_RET:   res_d.ret = 1'b1;
                default: res_d.bad = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_vld_o = res_q.vld;
    assign taken_o   = res_q.taken;
    assign nxt_pc_o  = res_q.npc;
    assign call_o    = res_q.call;
    assign helper_o  = res_q.helper;
    assign exit_o    = res_q.ret;
    assign illegal_o = res_q.bad;

endmodule

// File: rtl/jump_resolve_chk.sv
module jump_resolve_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_vld_i,
    input logic [PC_W-1:0] pc_i,
    input logic [3:0]      code_i,
    input logic            use_reg_i,
    input logic            half_i,
    input logic [3:0]      sub_i,
    input logic            out_vld_o,
    input logic            taken_o,
    input logic [PC_W-1:0] nxt_pc_o,
    input logic            call_o,
    input logic            helper_o,
    input logic            exit_o,
    input logic            illegal_o
);

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld_i |=> out_vld_o);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld_i |=> !out_vld_o && !taken_o && !call_o && !exit_o && !illegal_o);

    a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({call_o, exit_o, illegal_o}));

    a_r9_illegal_alone: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !taken_o && !call_o && !helper_o && !exit_o);

    a_r9_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld_i && code_i[3:1] == 3'b111 |=> illegal_o);

    a_r5_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld_i |=> (taken_o || nxt_pc_o == $past(pc_i) + PC_W'(1)));

    a_r6_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld_i && code_i == 4'h0 && !use_reg_i |=> taken_o && !illegal_o);

    a_r7_helper_call: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld_i && code_i == 4'h8 && !half_i && !use_reg_i && (sub_i == 4'd0 || sub_i == 4'd2)
        |=> call_o && helper_o && !taken_o);

    a_r8_return: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld_i && code_i == 4'h9 && !half_i && !use_reg_i
        |=> exit_o && !taken_o && nxt_pc_o == $past(pc_i) + PC_W'(1));

endmodule

bind jump_resolve jump_resolve_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld_i  (in_vld_i),
    .pc_i      (pc_i),
    .code_i    (code_i),
    .use_reg_i (use_reg_i),
    .half_i    (half_i),
    .sub_i     (sub_i),
    .out_vld_o (out_vld_o),
    .taken_o   (taken_o),
    .nxt_pc_o  (nxt_pc_o),
    .call_o    (call_o),
    .helper_o  (helper_o),
    .exit_o    (exit_o),
    .illegal_o (illegal_o)
);

// File: tb/test_jump_resolve.sv
`timescale 1ns/1ps
module test_jump_resolve;

    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld_i = 1'b0;
    logic [PW-1:0] pc_i = '0;
    logic [3:0]    code_i = '0;
    logic          use_reg_i = 1'b0;
    logic          half_i = 1'b0;
    logic [3:0]    sub_i = '0;
    logic [15:0]   ofs_i = '0;
    logic [31:0]   imm_i = '0;
    logic [63:0]   lhs_i = '0;
    logic [63:0]   rhs_i = '0;
    logic          out_vld_o, taken_o, call_o, helper_o, exit_o, illegal_o;
    logic [PW-1:0] nxt_pc_o;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    jump_resolve #(.PC_W(PW)) i_jump_resolve (
        .clk(clk), .rst_n(rst_n), .in_vld_i(in_vld_i), .pc_i(pc_i), .code_i(code_i),
        .use_reg_i(use_reg_i), .half_i(half_i), .sub_i(sub_i), .ofs_i(ofs_i),
        .imm_i(imm_i), .lhs_i(lhs_i), .rhs_i(rhs_i), .out_vld_o(out_vld_o),
        .taken_o(taken_o), .nxt_pc_o(nxt_pc_o), .call_o(call_o), .helper_o(helper_o),
        .exit_o(exit_o), .illegal_o(illegal_o)
    );

    // expected outputs packed as {vld, taken, call, helper, exit, illegal, npc}
    function automatic logic [PW+5:0] ref_model(
        input logic vld, input logic [PW-1:0] pc, input logic [3:0] code,
        input logic ureg, input logic half, input logic [3:0] sub,
        input logic [15:0] ofs, input logic [31:0] imm,
        input logic [63:0] a, input logic [63:0] b);
        logic [63:0] bsrc, ua, ub;
        longint signed sa, sb;
        int ia, ib, dsp;
        logic c, tk, cl, hl, ex, il;
        logic [PW-1:0] np;
        if (!vld) return '0;
        bsrc = ureg ? b : {{32{imm[31]}}, imm};
        if (half) begin
            ua = {32'd0, a[31:0]}; ub = {32'd0, bsrc[31:0]};
            ia = a[31:0]; ib = bsrc[31:0]; sa = ia; sb = ib;
        end else begin
            ua = a; ub = bsrc; sa = a; sb = bsrc;
        end
        tk = 0; cl = 0; hl = 0; ex = 0; il = 0; c = 0;
        dsp = int'($signed(ofs));
        case (code)
            4'h1: c = (ua == ub);
            4'h2: c = (ua > ub);
            4'h3: c = (ua >= ub);
            4'h4: c = ((ua & ub) != 0);
            4'h5: c = (ua != ub);
            4'h6: c = (sa > sb);
            4'h7: c = (sa >= sb);
            4'ha: c = (ua < ub);
            4'hb: c = (ua <= ub);
            4'hc: c = (sa < sb);
            4'hd: c = (sa <= sb);
            default: c = 0;
        endcase
        if (code == 4'h0) begin
            if (ureg) il = 1;
            else begin tk = 1; if (half) dsp = int'(imm); end
        end else if (code == 4'h8) begin
            if (ureg || half || sub > 4'd2) il = 1;
            else begin
                cl = 1;
                if (sub == 4'd1) begin tk = 1; dsp = int'(imm); end
                else hl = 1;
            end
        end else if (code == 4'h9) begin
            if (ureg || half) il = 1; else ex = 1;
        end else if (code >= 4'he) il = 1;
        else tk = c;
        np = tk ? PW'(int'(pc) + 1 + dsp) : PW'(int'(pc) + 1);
        return {1'b1, tk, cl, hl, ex, il, np};
    endfunction

    task automatic compare(input string req, input logic [PW+5:0] exp);
        logic [PW+5:0] act;
        act = {out_vld_o, taken_o, call_o, helper_o, exit_o, illegal_o, nxt_pc_o};
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h (vld,tk,call,help,exit,ill,npc)", req, act, exp);
        end
    endtask

    task automatic apply(input string req, input logic vld, input logic [PW-1:0] pc,
        input logic [3:0] code, input logic ureg, input logic half, input logic [3:0] sub,
        input logic [15:0] ofs, input logic [31:0] imm, input logic [63:0] a, input logic [63:0] b);
        logic [PW+5:0] exp;
        @(negedge clk);
        in_vld_i = vld; pc_i = pc; code_i = code; use_reg_i = ureg; half_i = half;
        sub_i = sub; ofs_i = ofs; imm_i = imm; lhs_i = a; rhs_i = b;
        exp = ref_model(vld, pc, code, ureg, half, sub, ofs, imm, a, b);
        @(posedge clk); #1;
        compare(req, exp);
    endtask

    function automatic string tag_of(input logic [3:0] code, input logic ureg,
        input logic half, input logic [3:0] sub);
        if (code >= 4'he) return "R9";
        if (code == 4'h0) return ureg ? "R9" : "R6";
        if (code == 4'h8) return (ureg || half || sub > 4'd2) ? "R9" : "R7";
        if (code == 4'h9) return (ureg || half) ? "R9" : "R8";
        if (half) return "R3";
        return ureg ? "R2" : "R4";
    endfunction

    initial begin
        #1_000_000;
        n_chk++; n_err++;
        $display("FAIL R10 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        // R1: inputs active during reset leave outputs at zero
        in_vld_i = 1'b1; code_i = 4'h0; pc_i = 16'h1234;
        repeat (3) @(posedge clk);
        #1 compare("R1 in reset", '0);
        @(negedge clk); rst_n = 1'b1; in_vld_i = 1'b0;
        @(posedge clk); #1 compare("R1 after release", '0);

        // R2 conditions with register operand
        apply("R2 eq taken", 1, 16'h0100, 4'h1, 1, 0, 0, 16'h0010, 0, 64'h55, 64'h55);
        apply("R2 ugt vs sgt", 1, 16'h0100, 4'h2, 1, 0, 0, 16'h0010, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
        apply("R2 sgt negative", 1, 16'h0100, 4'h6, 1, 0, 0, 16'h0010, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
        apply("R2 bit test zero", 1, 16'h0100, 4'h4, 1, 0, 0, 16'h0010, 0, 64'hF0, 64'h0F);
        apply("R2 sle equal", 1, 16'h0100, 4'hd, 1, 0, 0, 16'h0010, 0, 64'h7, 64'h7);
        // R3 compare width
        apply("R3 half eq ignores high", 1, 16'h0200, 4'h1, 1, 1, 0, 16'h0004, 0, 64'hAAAA_0000_0000_0042, 64'h0000_0000_0000_0042);
        apply("R3 full eq sees high", 1, 16'h0200, 4'h1, 1, 0, 0, 16'h0004, 0, 64'hAAAA_0000_0000_0042, 64'h0000_0000_0000_0042);
        apply("R3 half sign bit31", 1, 16'h0200, 4'h6, 1, 1, 0, 16'h0004, 0, 64'h8000_0000, 64'h1);
        apply("R3 full bit31 positive", 1, 16'h0200, 4'h6, 1, 0, 0, 16'h0004, 0, 64'h8000_0000, 64'h1);
        // R4 immediate source sign-extended
        apply("R4 imm sext eq", 1, 16'h0300, 4'h1, 0, 0, 0, 16'h0002, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        apply("R4 imm ignores rhs", 1, 16'h0300, 4'h5, 0, 0, 0, 16'h0002, 32'h5, 64'h5, 64'h9);
        // R5 displacement and wrap
        apply("R5 backward wrap", 1, 16'h0000, 4'h1, 1, 0, 0, 16'hFFFD, 0, 64'h1, 64'h1);
        apply("R5 fall wrap", 1, 16'hFFFF, 4'h1, 1, 0, 0, 16'h0008, 0, 64'h1, 64'h2);
        // R6 unconditional
        apply("R6 full uses offset", 1, 16'h0400, 4'h0, 0, 0, 0, 16'h0020, 32'h0000_1000, 0, 0);
        apply("R6 half uses imm", 1, 16'h0400, 4'h0, 0, 1, 0, 16'h0020, 32'h0001_1000, 0, 0);
        // R7 calls
        apply("R7 helper addr", 1, 16'h0500, 4'h8, 0, 0, 4'd0, 0, 32'd77, 0, 0);
        apply("R7 helper id", 1, 16'h0500, 4'h8, 0, 0, 4'd2, 0, 32'd78, 0, 0);
        apply("R7 local call", 1, 16'h0500, 4'h8, 0, 0, 4'd1, 0, 32'hFFFF_FF00, 0, 0);
        // R8 return
        apply("R8 exit", 1, 16'h0600, 4'h9, 0, 0, 0, 16'h0040, 0, 0, 0);
        // R9 undefined encodings
        apply("R9 code 14", 1, 16'h0700, 4'he, 1, 0, 0, 16'h0040, 0, 0, 0);
        apply("R9 ja register", 1, 16'h0700, 4'h0, 1, 0, 0, 16'h0040, 0, 0, 0);
        apply("R9 call half", 1, 16'h0700, 4'h8, 0, 1, 4'd1, 0, 32'd5, 0, 0);
        apply("R9 call subtype 3", 1, 16'h0700, 4'h8, 0, 0, 4'd3, 0, 32'd5, 0, 0);
        apply("R9 exit register", 1, 16'h0700, 4'h9, 1, 0, 0, 0, 0, 0, 0);
        // R10 idle cycle clears everything
        apply("R10 idle", 0, 16'h0800, 4'h0, 0, 0, 0, 16'h0040, 0, 0, 0);

        for (int i = 0; i < 4000; i++) begin
            logic [63:0] a, b;
            logic [3:0] cd, sb;
            logic ur, hf, vl;
            a  = {$urandom, $urandom};
            b  = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) b = {~a[63:32], a[31:0]};
            if ($urandom_range(0, 5) == 0) b = a;
            cd = 4'($urandom);
            sb = 4'($urandom_range(0, 3));
            ur = 1'($urandom);
            hf = 1'($urandom);
            vl = ($urandom_range(0, 9) != 0);
            apply(vl ? tag_of(cd, ur, hf, sb) : "R10", vl, PW'($urandom), cd, ur, hf, sb,
                  16'($urandom), $urandom, a, b);
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule